// File: doc/BRIEF.md
# SDRAM Command Legality Checker

This block watches the command lines of a two-bank SDRAM interface and reports any command that the present state of the device does not allow. Every cycle it decodes the chip select, row strobe, column strobe and write enable lines into one command. It keeps a small state machine per bank that records whether the bank is idle, running a refresh, or inside the short window that follows a mode register write. When a command breaks the rules for the state it is aimed at, the checker raises a one-cycle flag together with a code for that command. It takes no part in the bus traffic. It is meant to sit in a controller or a test harness next to the command bus.

The device returns to idle without help once the recovery time has passed. That time is a parameter (`T_RC`) after a refresh and a fixed two cycles after a mode register write. A second parameter (`T_RRD`) gives the least spacing between activates to different banks. Cycles in which the clock-enable line is low do not advance any recovery count. A command is only judged when clock enable was high in the cycle before it.

Top module: `sdram_cmd_guard`

## Requirements
- R1: When `illegal` is high, `illegal_code` names the offending command: 1 mode register set, 2 refresh, 3 precharge, 4 activate, 5 write, 6 write with auto precharge (`ap_bit`=1), 7 read, 8 read with auto precharge, 9 burst stop. The lines {row_strobe_n, col_strobe_n, wr_en_n} decode as 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop and 111 no-op. `chip_sel_n`=1 is deselect, whatever the other lines are.
- R2: The flag for a command sampled at one rising edge appears after the next edge and lasts one cycle. While `illegal` is low, `illegal_code` is 0.
- R3: While refreshing, mode set, refresh, precharge, activate, write and read are illegal. Burst stop, no-op and deselect are accepted.
- R4: A refresh accepted at edge t leaves the banks refreshing for the commands at the next T_RC-1 counted edges. The command at the T_RC-th counted edge is judged against idle banks. An edge is counted when `clk_en` is high at it.
- R5: In the cycle after an accepted mode register set, every command other than no-op and deselect is illegal, burst stop included. A command two counted edges after the mode set is judged against idle banks.
- R6: Mode register set and refresh are legal only when every bank is idle. An accepted one puts all banks in the refresh or mode-set state.
- R7: Read, write, activate and precharge are judged against the bank that `bank` selects. Precharge with `ap_bit`=1 is judged against all banks. An activate to the same bank as the previous activate carries no spacing rule.
- R8: An activate to a bank is illegal if fewer than T_RRD counted edges have passed since an accepted activate to another bank.
- R9: A command sampled when `clk_en` was low at the previous edge is not judged, produces no flag and changes no state.
- R10: A refresh sampled with `clk_en` low (self refresh) is accepted like a refresh. Its recovery count holds while `clk_en` stays low and resumes once it is high.
- R11: A synchronous reset puts every bank in idle, clears all counts and holds the flag and code at 0.
- R12: An illegal command changes no state: it neither restarts a recovery count nor starts an activate spacing window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Bus clock-enable line |
| chip_sel_n | input | 1 | Active-low chip select |
| row_strobe_n | input | 1 | Active-low row strobe |
| col_strobe_n | input | 1 | Active-low column strobe |
| wr_en_n | input | 1 | Active-low write enable |
| bank | input | BANK_W | Bank select |
| ap_bit | input | 1 | Auto-precharge / all-bank address bit |
| illegal | output | 1 | One-cycle flag for a forbidden command |
| illegal_code | output | 4 | Code of the forbidden command, 0 when no flag |

## Verification
The bench targets the last edge of each recovery window. An activate issued one cycle before the refresh window ends must be flagged, and one issued at the end must pass. A counter that is off by one flips one of the two results. It issues a refresh and a burst stop inside the refresh window to show that a rejected refresh that restarted the timer would flag a later legal command, and that burst stop is accepted during refresh but refused after a mode set. Activate pairs to different banks probe the spacing limit. Clock-enable sequences check that commands after a low cycle pass silently and that self refresh pauses its count. A long random run with a fixed seed compares every cycle against a model built from the rules.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

    localparam int CODE_W   = 4;
    localparam int MRS_HOLD = 2;

    typedef enum logic [3:0] {
        OP_DESEL, OP_NOP, OP_BST, OP_RD, OP_WR,
        OP_ACT, OP_PRE, OP_REF, OP_MRS
    } op_e;

    typedef enum logic [1:0] {
        BK_IDLE, BK_REFR, BK_MRS
    } bank_st_e;

    typedef struct packed {
        op_e  op;
        logic ap;
    } bus_cmd_t;

    function automatic op_e decode_op(input logic s_n, input logic r_n,
                                      input logic c_n, input logic w_n);
        op_e r;
        if (s_n) begin
            r = OP_DESEL;
        end else begin
            case ({r_n, c_n, w_n})
                3'b000:  r = OP_MRS;
                3'b001:  r = OP_REF;
                3'b010:  r = OP_PRE;
                3'b011:  r = OP_ACT;
                3'b100:  r = OP_WR;
                3'b101:  r = OP_RD;
                3'b110:  r = OP_BST;
                default: r = OP_NOP;
            endcase
        end
        return r;
    endfunction

    function automatic logic [CODE_W-1:0] code_of(input op_e op, input logic ap);
        logic [CODE_W-1:0] r;
        case (op)
            OP_MRS:  r = 4'd1;
            OP_REF:  r = 4'd2;
            OP_PRE:  r = 4'd3;
            OP_ACT:  r = 4'd4;
            OP_WR:   r = ap ? 4'd6 : 4'd5;
            OP_RD:   r = ap ? 4'd8 : 4'd7;
            OP_BST:  r = 4'd9;
            default: r = 4'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_guard_pkg::*;
(
    input  logic     chip_sel_n,
    input  logic     row_strobe_n,
    input  logic     col_strobe_n,
    input  logic     wr_en_n,
    input  logic     ap_bit,
    output bus_cmd_t cmd
);
    always_comb begin
        cmd.op = decode_op(chip_sel_n, row_strobe_n, col_strobe_n, wr_en_n);
        cmd.ap = ap_bit;
    end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
    import sdram_guard_pkg::*;
#(
    parameter int T_RC  = 7,
    parameter int T_RRD = 2,
    localparam int CW   = $clog2(T_RC + 1),
    localparam int RW   = (T_RRD > 1) ? $clog2(T_RRD + 1) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_en,
    input  logic start_ref,
    input  logic start_mrs,
    input  logic start_act,
    output logic busy,
    output logic in_mrs,
    output logic act_window
);
    bank_st_e        st;
    logic [CW-1:0]   left;
    logic [RW-1:0]   rrd;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= BK_IDLE;
            left <= '0;
            rrd  <= '0;
        end else begin
            if (st != BK_IDLE && clk_en) begin
                if (left <= CW'(1)) st <= BK_IDLE;
                else                left <= left - CW'(1);
            end
            if (clk_en && rrd != '0) rrd <= rrd - RW'(1);
            if (start_ref) begin
                st   <= BK_REFR;
                left <= CW'(T_RC - 1);
            end else if (start_mrs) begin
                st   <= BK_MRS;
                left <= CW'(MRS_HOLD - 1);
            end
            if (start_act) rrd <= RW'(T_RRD - 1);
        end
    end

    assign busy       = (st != BK_IDLE);
    assign in_mrs     = (st == BK_MRS);
    assign act_window = (rrd != '0);

    AST_MRS_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (st == BK_MRS && clk_en && !start_ref && !start_mrs) |=> (st == BK_IDLE)); // R5
    AST_SELF_REF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st == BK_REFR && !clk_en && !start_mrs) |=> (st == BK_REFR && $stable(left))); // R10
    AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (rst)
        left <= CW'(T_RC - 1)); // R4
    AST_RRD_BOUND: assert property (@(posedge clk) disable iff (rst)
        rrd <= RW'(T_RRD - 1)); // R8
endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
    import sdram_guard_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  bus_cmd_t             cmd,
    input  logic [BANK_W-1:0]    bank,
    input  logic [NUM_BANKS-1:0] busy,
    input  logic [NUM_BANKS-1:0] in_mrs,
    input  logic [NUM_BANKS-1:0] act_window,
    output logic                 viol
);
    logic [NUM_BANKS-1:0] hit;
    logic any_busy, any_mrs, other_win, sel_busy;

    always_comb begin
        hit       = '0;
        hit[bank] = 1'b1;
        any_busy  = |busy;
        any_mrs   = |in_mrs;
        other_win = |(act_window & ~hit);
        sel_busy  = |(busy & hit);
        case (cmd.op)
            OP_MRS, OP_REF: viol = any_busy;
            OP_BST:         viol = any_mrs;
            OP_PRE:         viol = cmd.ap ? any_busy : sel_busy;
            OP_ACT:         viol = sel_busy | other_win;
            OP_WR, OP_RD:   viol = sel_busy;
            default:        viol = 1'b0;
        endcase
    end
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sdram_guard_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int T_RC      = 7,
    parameter int T_RRD     = 2,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              chip_sel_n,
    input  logic              row_strobe_n,
    input  logic              col_strobe_n,
    input  logic              wr_en_n,
    input  logic [BANK_W-1:0] bank,
    input  logic              ap_bit,
    output logic              illegal,
    output logic [CODE_W-1:0] illegal_code
);
    bus_cmd_t             cmd;
    logic                 cke_q;
    logic                 viol, accept;
    logic [NUM_BANKS-1:0] busy, in_mrs, act_window;

    sdram_cmd_decode u_decode (
        .chip_sel_n  (chip_sel_n),
        .row_strobe_n(row_strobe_n),
        .col_strobe_n(col_strobe_n),
        .wr_en_n     (wr_en_n),
        .ap_bit      (ap_bit),
        .cmd         (cmd)
    );

    sdram_rule_check #(.NUM_BANKS(NUM_BANKS)) u_rules (
        .cmd       (cmd),
        .bank      (bank),
        .busy      (busy),
        .in_mrs    (in_mrs),
        .act_window(act_window),
        .viol      (viol)
    );

    assign accept = cke_q && !viol;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_track #(.T_RC(T_RC), .T_RRD(T_RRD)) u_track (
            .clk       (clk),
            .rst       (rst),
            .clk_en    (clk_en),
            .start_ref (accept && cmd.op == OP_REF),
            .start_mrs (accept && cmd.op == OP_MRS),
            .start_act (accept && cmd.op == OP_ACT && bank == BANK_W'(b)),
            .busy      (busy[b]),
            .in_mrs    (in_mrs[b]),
            .act_window(act_window[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q        <= 1'b1;
            illegal      <= 1'b0;
            illegal_code <= '0;
        end else begin
            cke_q        <= clk_en;
            illegal      <= cke_q && viol;
            illegal_code <= (cke_q && viol) ? code_of(cmd.op, cmd.ap) : '0;
        end
    end

    AST_UNCHECKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cke_q |=> !illegal); // R9
    AST_CODE_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !illegal |-> illegal_code == '0); // R2
    AST_CODE_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        illegal |-> illegal_code != '0); // R1
    AST_NOP_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        (cke_q && (cmd.op == OP_NOP || cmd.op == OP_DESEL)) |=> !illegal); // R3
    AST_BUSY_BANK_ACT: assert property (@(posedge clk) disable iff (rst)
        (cke_q && cmd.op == OP_ACT && busy[bank]) |=> (illegal && illegal_code == 4'd4)); // R7
    AST_MRS_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cke_q && cmd.op == OP_MRS && (|busy)) |=> (illegal && illegal_code == 4'd1)); // R6
endmodule

// File: tb/sdram_cmd_guard_tb.sv
module sdram_cmd_guard_tb;
    localparam int T_RC  = 7;
    localparam int T_RRD = 2;
    localparam int K_MRS = 0, K_REF = 1, K_PRE = 2, K_ACT = 3, K_WR = 4,
                   K_RD = 5, K_BST = 6, K_NOP = 7, K_DES = 8;

    logic clk = 1'b0;
    logic rst, clk_en, chip_sel_n, row_strobe_n, col_strobe_n, wr_en_n, ap_bit;
    logic [0:0] bank;
    logic       illegal;
    logic [3:0] illegal_code;

    int checks = 0, errors = 0;
    bit done = 0;

    int  m_kind [2];
    int  m_left [2];
    int  m_rrd  [2];
    bit  m_ckeq;

    always #5 clk = ~clk;

    sdram_cmd_guard #(.NUM_BANKS(2), .T_RC(T_RC), .T_RRD(T_RRD)) u_dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .chip_sel_n(chip_sel_n),
        .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n),
        .wr_en_n(wr_en_n), .bank(bank), .ap_bit(ap_bit),
        .illegal(illegal), .illegal_code(illegal_code)
    );

    function automatic int exp_code(input int k, input bit ap);
        case (k)
            K_MRS: return 1;
            K_REF: return 2;
            K_PRE: return 3;
            K_ACT: return 4;
            K_WR:  return ap ? 6 : 5;
            K_RD:  return ap ? 8 : 7;
            K_BST: return 9;
            default: return 0;
        endcase
    endfunction

    function automatic bit rule_broken(input int k, input bit b, input bit ap);
        bit any_busy = (m_kind[0] != 0) || (m_kind[1] != 0);
        bit any_mrs  = (m_kind[0] == 2) || (m_kind[1] == 2);
        case (k)
            K_MRS, K_REF: return any_busy;
            K_BST:        return any_mrs;
            K_PRE:        return ap ? any_busy : (m_kind[b] != 0);
            K_ACT:        return (m_kind[b] != 0) || (m_rrd[!b] != 0);
            K_WR, K_RD:   return m_kind[b] != 0;
            default:      return 1'b0;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_kind[i] = 0; m_left[i] = 0; m_rrd[i] = 0;
        end
        m_ckeq = 1'b1;
    endtask

    task automatic check(input bit ok, input string tag, input int act_f, input int act_c,
                         input int exp_f, input int exp_c);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: illegal=%0d code=%0d expected illegal=%0d code=%0d",
                     tag, act_f, act_c, exp_f, exp_c);
        end
    endtask

    task automatic step(input bit c, input int k, input bit b, input bit ap, input string tag);
        bit viol, flag;
        int code;
        clk_en = c; bank = b; ap_bit = ap;
        if (k == K_DES) begin
            chip_sel_n = 1'b1;
            {row_strobe_n, col_strobe_n, wr_en_n} = 3'($urandom);
        end else begin
            chip_sel_n = 1'b0;
            {row_strobe_n, col_strobe_n, wr_en_n} = 3'(k);
        end
        viol = rule_broken(k, b, ap);
        flag = m_ckeq && viol;
        code = flag ? exp_code(k, ap) : 0;
        for (int i = 0; i < 2; i++) begin
            if (m_kind[i] != 0 && c) begin
                if (m_left[i] <= 1) m_kind[i] = 0;
                else                m_left[i]--;
            end
            if (c && m_rrd[i] > 0) m_rrd[i]--;
        end
        if (m_ckeq && !viol) begin
            if (k == K_REF)
                for (int i = 0; i < 2; i++) begin m_kind[i] = 1; m_left[i] = T_RC - 1; end
            else if (k == K_MRS)
                for (int i = 0; i < 2; i++) begin m_kind[i] = 2; m_left[i] = 1; end
            else if (k == K_ACT)
                m_rrd[b] = T_RRD - 1;
        end
        m_ckeq = c;
        @(negedge clk);
        check(illegal === flag && int'(illegal_code) == code, tag,
              int'(illegal), int'(illegal_code), int'(flag), code);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check(illegal === 1'b0 && illegal_code == 4'd0, tag,
              int'(illegal), int'(illegal_code), 0, 0);
    endtask

    task automatic idle_wait(input int n);
        for (int i = 0; i < n; i++) step(1'b1, K_NOP, 1'b0, 1'b0, "R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: illegal=%0d code=%0d expected run to finish", illegal, illegal_code);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; clk_en = 1'b1; chip_sel_n = 1'b1; row_strobe_n = 1'b1;
        col_strobe_n = 1'b1; wr_en_n = 1'b1; bank = 1'b0; ap_bit = 1'b0;
        model_reset();
        @(negedge clk);
        do_reset("R11");

        // refresh window: R3 rejections and acceptances, R12 no restart, R4 boundary
        step(1, K_REF, 0, 0, "R6");
        step(1, K_ACT, 0, 0, "R3");
        step(1, K_BST, 0, 0, "R3");
        step(1, K_REF, 0, 0, "R12");
        step(1, K_NOP, 0, 0, "R3");
        step(1, K_DES, 0, 0, "R3");
        step(1, K_ACT, 1, 0, "R4");
        step(1, K_ACT, 0, 0, "R4");
        idle_wait(3);

        // mode register window: R5 burst stop refused, idle after two
        step(1, K_MRS, 0, 0, "R6");
        step(1, K_BST, 0, 0, "R5");
        step(1, K_RD,  1, 1, "R5");
        step(1, K_MRS, 0, 0, "R6");
        step(1, K_WR,  0, 1, "R1");
        step(1, K_REF, 0, 0, "R6");
        step(1, K_MRS, 0, 0, "R6");
        step(1, K_PRE, 1, 1, "R7");
        step(1, K_RD,  0, 0, "R1");
        idle_wait(T_RC);

        // activate spacing: R8 and R7
        step(1, K_ACT, 0, 0, "R8");
        step(1, K_ACT, 1, 0, "R8");
        step(1, K_ACT, 1, 0, "R8");
        step(1, K_ACT, 1, 0, "R7");
        step(1, K_ACT, 0, 0, "R8");
        step(1, K_PRE, 0, 0, "R7");
        idle_wait(3);

        // clock enable low: R9 command ignored
        step(0, K_NOP, 0, 0, "R9");
        step(1, K_REF, 0, 0, "R9");
        step(1, K_ACT, 0, 0, "R9");
        idle_wait(3);

        // self refresh: R10 count paused while clock enable is low
        step(0, K_REF, 0, 0, "R10");
        for (int i = 0; i < 12; i++) step(0, K_NOP, 0, 0, "R10");
        for (int i = 0; i < 4; i++) step(1, K_NOP, 0, 0, "R10");
        step(1, K_ACT, 0, 0, "R10");
        step(1, K_ACT, 0, 0, "R10");
        idle_wait(T_RC);

        // reset while busy: R11
        step(1, K_REF, 0, 0, "R6");
        do_reset("R11");
        step(1, K_ACT, 1, 0, "R11");

        // constrained random run
        for (int n = 0; n < 4000; n++) begin
            int r;
            int k;
            bit c;
            r = int'($urandom % 16);
            case (r)
                6:       k = K_DES;
                7:       k = K_MRS;
                8:       k = K_REF;
                9:       k = K_PRE;
                10, 11:  k = K_ACT;
                12:      k = K_WR;
                13:      k = K_RD;
                14:      k = K_BST;
                default: k = K_NOP;
            endcase
            c = ($urandom % 10) != 0;
            step(c, k, 1'($urandom), 1'($urandom), "R2");
        end

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule